// File: doc/BRIEF.md
# Dual-Mode Burst Address Counter

This block produces the addresses for a four-beat burst on a synchronous pipelined SRAM interface. A load strobe captures a complete starting address. Each later rising edge with the active-low advance input low moves the burst one beat forward. Only the low address bits change. The upper bits stay at the loaded value for the whole burst. Read bursts and write bursts use the counter in the same way.

Two burst orders are available. The interleaved order forms the low bits as the start value XOR the beat number. The linear order adds the beat number to the start value and wraps modulo four. The order is captured together with the address on load, so one burst uses a single order from start to end. The block drives the current full address and the beat index. Both come straight from registers and change one cycle after the edge that sampled the inputs. All control pins are plain level signals with no handshake.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active and right after it, `addr_o` is 0, `beat_o` is 0 and the captured order is interleaved.
- R2: With `load_i` high at a rising edge, `addr_o` equals `addr_i` and `beat_o` is 0 from the following cycle.
- R3: When `load_i` and an advance (`adv_n_i` low) fall on the same edge, the load wins and `beat_o` is 0.
- R4: With `load_i` low and `adv_n_i` low at a rising edge, `beat_o` increases by one, modulo 4.
- R5: With `load_i` low and `adv_n_i` high at a rising edge, `addr_o` and `beat_o` keep their values.
- R6: When `mode_i` was 0 at load (interleaved), `addr_o[1:0]` equals start[1:0] XOR `beat_o`. Start 01 gives 01, 00, 11, 10.
- R7: When `mode_i` was 1 at load (linear), `addr_o[1:0]` equals (start[1:0] + `beat_o`) mod 4. Start 11 gives 11, 00, 01, 10.
- R8: Between loads, `addr_o[ADDR_W-1:2]` does not change.
- R9: One more advance after the fourth beat brings `beat_o` back to 0 and `addr_o` back to the start address, in both orders.
- R10: `mode_i` is sampled only on a load edge. A change of `mode_i` during a burst has no effect on `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Starts a burst: captures `addr_i` and `mode_i` |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Burst order: 0 = interleaved, 1 = linear |
| addr_i | input | ADDR_W (16) | Starting address of the burst |
| addr_o | output | ADDR_W (16) | Current burst address |
| beat_o | output | BURST_BITS (2) | Beat index within the burst |

## Verification
Every result is due exactly one cycle after the rising edge that samples `load_i`, `adv_n_i`, `mode_i` and `addr_i`. No result needs more than one edge, because both outputs are set by the base, beat and order registers alone. The driver changes inputs on the falling edge. For each stimulus it queues the address and beat it expects after the next rising edge. The monitor takes one queued item per cycle and compares it 1 ns after that rising edge. It is therefore never early and never more than one cycle late. Hold cycles and mid-burst mode changes queue an unchanged value, so the check for "no effect" is made in the same cycle that would show an effect.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst ordering captured at load time
  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  adv_n_i,
  output logic [BURST_BITS-1:0] beat_o
);

  localparam logic [BURST_BITS-1:0] BEAT_ONE = BURST_BITS'(1);

  logic [BURST_BITS-1:0] beat_q;

  // Load outranks advance; the counter wraps naturally at 2**BURST_BITS
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (load_i) begin
      beat_q <= '0;
    end else if (!adv_n_i) begin
      beat_q <= beat_q + BEAT_ONE;
    end
  end

  assign beat_o = beat_q;

  AST_LOAD_CLEARS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0)); // R3

  AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> (beat_o == $past(beat_o) + BEAT_ONE)); // R4

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> $stable(beat_o)); // R5

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_pkg::*;
#(
  parameter int BURST_BITS = 2
) (
  input  logic [BURST_BITS-1:0] start_i,
  input  logic [BURST_BITS-1:0] beat_i,
  input  burst_order_e          order_i,
  output logic [BURST_BITS-1:0] low_o
);

  logic [BURST_BITS-1:0] xor_seq;
  logic [BURST_BITS-1:0] lin_seq;

  // Interleaved order: each bit toggles independently
  for (genvar b = 0; b < BURST_BITS; b++) begin : g_xor_bit
    assign xor_seq[b] = start_i[b] ^ beat_i[b];
  end

  // Linear order: modular add, carry out of the field is discarded
  assign lin_seq = start_i + beat_i;

  always_comb begin
    unique case (order_i)
      ORD_LINEAR:      low_o = lin_seq;
      ORD_INTERLEAVED: low_o = xor_seq;
      default:         low_o = xor_seq;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  adv_n_i,
  input  logic                  mode_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [BURST_BITS-1:0] beat_o
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     base_q;
  burst_order_e          order_q;
  logic [BURST_BITS-1:0] beat;
  logic [BURST_BITS-1:0] low;

  // Start address and order are captured only on load
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVED;
    end else if (load_i) begin
      base_q  <= addr_i;
      order_q <= burst_order_e'(mode_i);
    end
  end

  burst_beat_ctr #(
    .BURST_BITS(BURST_BITS)
  ) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .adv_n_i(adv_n_i),
    .beat_o (beat)
  );

  burst_seq_gen #(
    .BURST_BITS(BURST_BITS)
  ) u_seq (
    .start_i(base_q[BURST_BITS-1:0]),
    .beat_i (beat),
    .order_i(order_q),
    .low_o  (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BURST_BITS], low};
  assign beat_o = beat;

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (addr_o == $past(addr_i))); // R2

  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (addr_o[ADDR_W-1:BURST_BITS] == $past(addr_o[ADDR_W-1:BURST_BITS]))); // R8

  AST_BEAT0_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_o == '0) |-> (addr_o == base_q)); // R9

  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(order_q)); // R10

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> $stable(addr_o)); // R5

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed BURST_BITS");
  end

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

  localparam int AW = 16;
  localparam int BB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_n_i = 1'b1;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [BB-1:0] beat_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  logic [BB-1:0] m_beat = '0;
  logic          m_lin  = 1'b0;

  logic [AW+BB-1:0] q_exp[$];
  string            q_tag[$];

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
    .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [BB-1:0] lo;
    lo = m_lin ? (m_base[BB-1:0] + m_beat) : (m_base[BB-1:0] ^ m_beat);
    return {m_base[AW-1:BB], lo};
  endfunction

  // Driver: one stimulus per cycle, expected post-edge state queued
  task automatic step(input logic ld, input logic advn, input logic md,
                      input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    load_i = ld; adv_n_i = advn; mode_i = md; addr_i = a;
    if (ld) begin
      m_base = a; m_beat = '0; m_lin = md;
    end else if (!advn) begin
      m_beat = m_beat + 2'd1;
    end
    q_exp.push_back({model_addr(), m_beat});
    q_tag.push_back(tag);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [AW+BB-1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_run++;
      if ({addr_o, beat_o} !== e) begin
        n_fail++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 t, addr_o, beat_o, e[AW+BB-1:BB], e[BB-1:0]);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_run++;
    if (addr_o !== '0 || beat_o !== '0) begin
      n_fail++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0000 beat=0", addr_o, beat_o);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 R6 R9: interleaved from start 01, full burst plus wrap
    step(1, 1, 0, 16'h1A1, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 16'h0, "R6");
    step(0, 0, 0, 16'h0, "R9");
    // R5: holds with advance high, R10: mode toggled mid-burst
    step(0, 0, 1, 16'hFFFF, "R10");
    step(0, 1, 1, 16'h0, "R5");
    step(0, 1, 0, 16'h0, "R5");
    step(0, 0, 1, 16'h0, "R10");
    // R6 with start 11
    step(1, 1, 0, 16'hBEEF, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 16'h0, "R6");
    // R7 linear from 01 and from 11, with wrap
    step(1, 1, 1, 16'h5A5D, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 16'h0, "R7");
    step(0, 0, 0, 16'h0, "R9");
    step(1, 1, 1, 16'hC003, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 16'h1234, "R7");
    step(0, 0, 1, 16'h0, "R9");
    // R3: load with advance in the same cycle, then mid-burst reload
    step(0, 0, 1, 16'h0, "R4");
    step(1, 0, 0, 16'h7772, "R3");
    step(0, 0, 1, 16'h0, "R4");
    step(1, 0, 1, 16'h0002, "R3");
    step(0, 0, 0, 16'hFFFF, "R8");
    step(0, 0, 0, 16'hFFFF, "R8");
    step(0, 1, 0, 16'h0, "R5");
    @(negedge clk);
    load_i = 0; adv_n_i = 1;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule